// File: doc/BRIEF.md
# Partitionable Multi-Stage Trigger Sequencer

This block turns a stream of 8-bit match-flag samples into a capture trigger. It holds a pool of sixteen stages. A partition mode splits the pool into as many as four independent sequencers, and all of them step in parallel on each accepted sample. Each stage waits for its own combination of match flags. The stage must see that combination a programmed number of times before its sequencer moves on to the next stage. A sequencer completes when its last stage is satisfied. Once complete, it stays complete until the block is re-armed.

The trigger output ORs two sources. The first is the completion of any sequencers chosen by a select mask. The second is a sum-of-products term built from eight products over the match flags. The trigger is registered and sticky. A companion single-cycle pulse marks the moment it first rises, for the capture controller. Samples arrive on a valid/ready interface. The block never applies back-pressure: ready is high on every cycle after reset, and a cycle without valid leaves all state unchanged. All configuration inputs are plain levels. Software changes them only around an arm pulse.

Top module: `trig_seq_pool`

## Requirements
- R1: `part_mode` selects how the stages are split, with stage ranges inclusive. 0 gives sequencer 0 = stages 0..15. 1 gives sequencer 0 = 0..7 and sequencer 1 = 8..15. 2 gives sequencer k = 4k..4k+3. 3 gives sequencer 0 = 0..7, sequencer 1 = 8..11 and sequencer 2 = 12..15. 4 gives sequencer 0 = 0..11 and sequencer 1 = 12..15. Codes 5..7 behave as code 0.
- R2: The condition of stage i is true on a sample when every flag bit set in `stage_mask[i*8+:8]` is also set in `smp_flags`. A zero mask is always true.
- R3: A stage counts accepted samples on which its condition holds, and these samples need not be consecutive. When the count reaches `stage_pass[i*20+:20]`, the sequencer advances. A pass value of 0 or 1 advances on the first occurrence.
- R4: When the last stage of a sequencer completes, `seq_fired[k]` sets one cycle later. The sequencer then holds its final stage until `arm` is asserted. `arm` returns every sequencer to stage 0 and clears `seq_fired`, `trig_out` and `trig_pulse`.
- R5: A sequencer that the current mode does not use stays at stage 0 and never fires.
- R6: Product p uses the flags set in `sop_term[p*8+:8]`. It is true when all those flags are set, and a zero term is never true. The sum-of-products hit is the OR of the eight products, taken on accepted samples only and only while `sop_en` is 1.
- R7: `trig_out` goes high one cycle after a sample on which any of these holds: a sequencer k with `trig_sel[k]` = 1 completes, or the sum-of-products hit is true. Sequencers whose select bit is 0 do not drive it. `trig_out` stays high until `arm`.
- R8: `trig_pulse` is high for exactly the one cycle in which `trig_out` rises. A later qualifying sample does not pulse it again.
- R9: `smp_ready` is 0 during reset and 1 on every cycle afterwards. A sample with `smp_valid` = 0 changes neither stages, counts nor outputs.
- R10: After reset, all stages read 0, and `seq_fired`, `trig_out` and `trig_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Restart all sequencers and clear the trigger |
| part_mode | input | 3 | Pool partition code |
| stage_mask | input | 128 | Per-stage flag mask, stage i at [i*8+:8] |
| stage_pass | input | 320 | Per-stage pass count, stage i at [i*20+:20] |
| sop_term | input | 64 | Product-term flag selects, product p at [p*8+:8] |
| sop_en | input | 1 | Enable the sum-of-products trigger source |
| trig_sel | input | 4 | Sequencer completions that drive the trigger |
| smp_valid | input | 1 | Sample present |
| smp_ready | output | 1 | Sample accepted (high after reset) |
| smp_flags | input | 8 | Match-circuit flags of the sample |
| seq_stage | output | 16 | Current stage of sequencer k at [k*4+:4], relative to its first stage |
| seq_fired | output | 4 | Sticky completion flag per sequencer |
| trig_out | output | 1 | Registered sticky trigger |
| trig_pulse | output | 1 | One-cycle pulse when trig_out rises |

## Verification
Each sequencer's current stage is exposed on `seq_stage`. A wrong partition base, a misread mask or a miscounted pass therefore shows on the sample after the fault, as a stage number that did not advance or that advanced too early. Corrupt counters or fired flags show through `seq_fired` and `trig_out` one cycle after the sample that should have completed the sequence. A missing pulse or a repeated pulse appears on `trig_pulse` in that same cycle, or on a later qualifying sample.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  localparam int unsigned POOL_STAGES = 16;
  localparam int unsigned POOL_SEQS   = 4;
  localparam int unsigned STG_W       = $clog2(POOL_STAGES);
  localparam int unsigned LEN_W       = STG_W + 1;

  typedef enum logic [2:0] {
    PM_ONE16  = 3'd0,
    PM_TWO8   = 3'd1,
    PM_FOUR4  = 3'd2,
    PM_8_4_4  = 3'd3,
    PM_12_4   = 3'd4
  } part_mode_e;

  typedef struct packed {
    logic [STG_W-1:0] base;
    logic [LEN_W-1:0] len;
  } seq_span_t;

  // Stage window owned by sequencer s under mode m; len 0 means unused.
  function automatic seq_span_t span_of(input logic [2:0] m, input int s);
    seq_span_t r;
    r.base = '0;
    r.len  = '0;
    case (m)
      PM_TWO8: begin
        if (s < 2) begin r.base = STG_W'(8 * s); r.len = LEN_W'(8); end
      end
      PM_FOUR4: begin
        r.base = STG_W'(4 * s); r.len = LEN_W'(4);
      end
      PM_8_4_4: begin
        if (s == 0)      begin r.base = STG_W'(0);  r.len = LEN_W'(8); end
        else if (s == 1) begin r.base = STG_W'(8);  r.len = LEN_W'(4); end
        else if (s == 2) begin r.base = STG_W'(12); r.len = LEN_W'(4); end
      end
      PM_12_4: begin
        if (s == 0)      begin r.base = STG_W'(0);  r.len = LEN_W'(12); end
        else if (s == 1) begin r.base = STG_W'(12); r.len = LEN_W'(4);  end
      end
      default: begin
        if (s == 0) begin r.base = '0; r.len = LEN_W'(16); end
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/trig_part_map.sv
module trig_part_map
  import trig_seq_pkg::*;
#(
  parameter int unsigned NSEQ = POOL_SEQS
) (
  input  logic [2:0]             mode,
  output logic [NSEQ*STG_W-1:0]  seq_base,
  output logic [NSEQ*LEN_W-1:0]  seq_len
);

  for (genvar s = 0; s < NSEQ; s++) begin : g_span
    seq_span_t sp;
    always_comb begin
      sp = span_of(mode, s);
      seq_base[s*STG_W +: STG_W] = sp.base;
      seq_len[s*LEN_W +: LEN_W]  = sp.len;
    end
  end

endmodule

// File: rtl/trig_sop.sv
module trig_sop #(
  parameter int unsigned NFLAG = 8,
  parameter int unsigned NPROD = 8
) (
  input  logic [NFLAG-1:0]       flags,
  input  logic [NPROD*NFLAG-1:0] terms,
  input  logic                   qual,
  output logic                   hit
);

  logic [NPROD-1:0] prod;

  for (genvar p = 0; p < NPROD; p++) begin : g_prod
    logic [NFLAG-1:0] t;
    assign t       = terms[p*NFLAG +: NFLAG];
    assign prod[p] = (|t) && (&(flags | ~t));
  end

  assign hit = qual && (|prod);

endmodule

// File: rtl/trig_seq_engine.sv
module trig_seq_engine
  import trig_seq_pkg::*;
#(
  parameter int unsigned NFLAG = 8,
  parameter int unsigned CNT_W = 20,
  parameter int unsigned NST   = POOL_STAGES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm,
  input  logic                   smp_valid,
  input  logic [NFLAG-1:0]       flags,
  input  logic [NST*NFLAG-1:0]   stage_mask,
  input  logic [NST*CNT_W-1:0]   stage_pass,
  input  logic [STG_W-1:0]       base,
  input  logic [LEN_W-1:0]       len,
  output logic [STG_W-1:0]       cur_stage,
  output logic                   fired,
  output logic                   fire_now
);

  logic [STG_W-1:0] cur_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic [STG_W-1:0] idx;
  logic [NFLAG-1:0] mask;
  logic [CNT_W-1:0] pass;
  logic             active, cond, reached, last, take;

  assign idx     = base + cur_q;
  assign mask    = stage_mask[int'(idx)*NFLAG +: NFLAG];
  assign pass    = stage_pass[int'(idx)*CNT_W +: CNT_W];
  assign active  = (len != '0) && ({1'b0, cur_q} < len);
  assign cond    = &(flags | ~mask);
  assign reached = ({1'b0, cnt_q} + 1'b1) >= {1'b0, pass};
  assign last    = ({1'b0, cur_q} + 1'b1) == len;
  assign take    = smp_valid && active && !fired_q && cond;
  assign fire_now = take && reached && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (arm || !active) begin
      cur_q   <= '0;
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (take) begin
      if (reached) begin
        cnt_q <= '0;
        if (last) fired_q <= 1'b1;
        else      cur_q   <= cur_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cur_stage = cur_q;
  assign fired     = fired_q;

  // R4
  fired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !arm && len != '0 && $stable(len)) |=> fired_q);

  // R5
  unused_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len == '0) |=> (cur_q == '0 && !fired_q));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !arm && active) |=> ($stable(cur_q) && $stable(cnt_q) && $stable(fired_q)));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && active && !fired_q) |=> (cur_q == $past(cur_q) || cur_q == $past(cur_q) + 1'b1));

endmodule

// File: rtl/trig_seq_pool.sv
module trig_seq_pool
  import trig_seq_pkg::*;
#(
  parameter int unsigned NFLAG = 8,
  parameter int unsigned CNT_W = 20,
  parameter int unsigned NPROD = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           arm,
  input  logic [2:0]                     part_mode,
  input  logic [POOL_STAGES*NFLAG-1:0]   stage_mask,
  input  logic [POOL_STAGES*CNT_W-1:0]   stage_pass,
  input  logic [NPROD*NFLAG-1:0]         sop_term,
  input  logic                           sop_en,
  input  logic [POOL_SEQS-1:0]           trig_sel,
  input  logic                           smp_valid,
  output logic                           smp_ready,
  input  logic [NFLAG-1:0]               smp_flags,
  output logic [POOL_SEQS*STG_W-1:0]     seq_stage,
  output logic [POOL_SEQS-1:0]           seq_fired,
  output logic                           trig_out,
  output logic                           trig_pulse
);

  logic [POOL_SEQS*STG_W-1:0] base_w;
  logic [POOL_SEQS*LEN_W-1:0] len_w;
  logic [POOL_SEQS-1:0]       fire_now;
  logic                       sop_hit, trig_d, rdy_q;

  trig_part_map #(.NSEQ(POOL_SEQS)) i_map (
    .mode     (part_mode),
    .seq_base (base_w),
    .seq_len  (len_w)
  );

  for (genvar s = 0; s < POOL_SEQS; s++) begin : g_seq
    trig_seq_engine #(.NFLAG(NFLAG), .CNT_W(CNT_W), .NST(POOL_STAGES)) i_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .smp_valid  (smp_valid),
      .flags      (smp_flags),
      .stage_mask (stage_mask),
      .stage_pass (stage_pass),
      .base       (base_w[s*STG_W +: STG_W]),
      .len        (len_w[s*LEN_W +: LEN_W]),
      .cur_stage  (seq_stage[s*STG_W +: STG_W]),
      .fired      (seq_fired[s]),
      .fire_now   (fire_now[s])
    );
  end

  trig_sop #(.NFLAG(NFLAG), .NPROD(NPROD)) i_sop (
    .flags (smp_flags),
    .terms (sop_term),
    .qual  (smp_valid && sop_en),
    .hit   (sop_hit)
  );

  assign trig_d = (|(fire_now & trig_sel)) || sop_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_out   <= 1'b0;
      trig_pulse <= 1'b0;
      rdy_q      <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (arm) begin
        trig_out   <= 1'b0;
        trig_pulse <= 1'b0;
      end else begin
        trig_out   <= trig_out || trig_d;
        trig_pulse <= trig_d && !trig_out;
      end
    end
  end

  assign smp_ready = rdy_q;

  // R8
  pulse_with_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> trig_out);

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R8
  rise_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> trig_pulse);

  // R7
  trig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && !arm) |=> trig_out);

  // R9
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> smp_ready);

endmodule

// File: tb/test_trig_seq_pool.sv
module test_trig_seq_pool;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         arm = 1'b0;
  logic [2:0]   part_mode = 3'd0;
  logic [127:0] stage_mask;
  logic [319:0] stage_pass;
  logic [63:0]  sop_term;
  logic         sop_en = 1'b0;
  logic [3:0]   trig_sel = 4'd0;
  logic         smp_valid = 1'b0;
  logic         smp_ready;
  logic [7:0]   smp_flags = 8'd0;
  logic [15:0]  seq_stage;
  logic [3:0]   seq_fired;
  logic         trig_out, trig_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trig_seq_pool i_trig_seq_pool (
    .clk(clk), .rst_n(rst_n), .arm(arm), .part_mode(part_mode),
    .stage_mask(stage_mask), .stage_pass(stage_pass), .sop_term(sop_term),
    .sop_en(sop_en), .trig_sel(trig_sel), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_flags(smp_flags), .seq_stage(seq_stage),
    .seq_fired(seq_fired), .trig_out(trig_out), .trig_pulse(trig_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_default();
    for (int i = 0; i < 16; i++) begin
      stage_mask[i*8 +: 8]  = 8'h80;
      stage_pass[i*20 +: 20] = 20'd1;
    end
    sop_term = '0;
    sop_en   = 1'b0;
    trig_sel = 4'd0;
  endtask

  task automatic send(input logic v, input logic [7:0] f);
    @(negedge clk);
    smp_valid = v;
    smp_flags = f;
  endtask

  task automatic settle();
    @(negedge clk);
    smp_valid = 1'b0;
    smp_flags = 8'd0;
  endtask

  task automatic do_arm();
    @(negedge clk);
    smp_valid = 1'b0;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 stages", {16'd0, seq_stage}, 32'd0);
    chk("R10 fired", {28'd0, seq_fired}, 32'd0);
    chk("R10 trig", {30'd0, trig_out, trig_pulse}, 32'd0);
    chk("R9 ready", {31'd0, smp_ready}, 32'd1);
  endtask

  task automatic t_four4();
    cfg_default();
    part_mode = 3'd2;
    stage_mask[0*8 +: 8] = 8'h01;
    stage_mask[1*8 +: 8] = 8'h02;
    stage_pass[1*20 +: 20] = 20'd3;
    stage_mask[2*8 +: 8] = 8'h04;
    stage_mask[3*8 +: 8] = 8'h00;
    trig_sel = 4'b0001;
    do_arm();
    send(1, 8'h01); settle();
    chk("R1 R2 stage0 advance", {28'd0, seq_stage[3:0]}, 32'd1);
    send(1, 8'h02); send(1, 8'h00); send(1, 8'h02); settle();
    chk("R3 two of three", {28'd0, seq_stage[3:0]}, 32'd1);
    send(0, 8'h02); settle();
    chk("R9 invalid ignored", {28'd0, seq_stage[3:0]}, 32'd1);
    send(1, 8'h02); settle();
    chk("R3 third occurrence", {28'd0, seq_stage[3:0]}, 32'd2);
    send(1, 8'h05); settle();
    chk("R2 masked and", {28'd0, seq_stage[3:0]}, 32'd3);
    chk("R7 not yet", {31'd0, trig_out}, 32'd0);
    send(1, 8'h00); settle();
    chk("R2 R4 empty mask fires", {28'd0, seq_fired}, 32'd1);
    chk("R7 trig one cycle after", {30'd0, trig_out, trig_pulse}, 32'd3);
    chk("R1 other seqs idle", {20'd0, seq_stage[15:4]}, 32'd0);
    settle();
    chk("R8 pulse one cycle", {30'd0, trig_out, trig_pulse}, 32'd2);
    send(1, 8'h00); settle();
    chk("R4 holds last stage", {27'd0, seq_fired[0], seq_stage[3:0]}, 32'h13);
    do_arm();
    chk("R4 arm clears", {10'd0, seq_stage, seq_fired, trig_out, trig_pulse}, 32'd0);
  endtask

  task automatic t_twelve4();
    cfg_default();
    part_mode = 3'd4;
    for (int i = 12; i < 16; i++) stage_mask[i*8 +: 8] = 8'h10;
    trig_sel = 4'b0001;
    do_arm();
    for (int n = 0; n < 4; n++) send(1, 8'h10);
    settle();
    chk("R1 seq1 at 12..15 fired", {28'd0, seq_fired}, 32'b0010);
    chk("R7 unselected no trig", {31'd0, trig_out}, 32'd0);
    chk("R5 unused idle", {24'd0, seq_stage[15:8]}, 32'd0);
    chk("R1 seq0 waits", {28'd0, seq_stage[3:0]}, 32'd0);
    do_arm();
  endtask

  task automatic t_one16();
    cfg_default();
    part_mode = 3'd0;
    for (int i = 0; i < 16; i++) stage_mask[i*8 +: 8] = 8'h00;
    stage_pass[15*20 +: 20] = 20'd0;
    trig_sel = 4'b0001;
    do_arm();
    for (int n = 0; n < 15; n++) send(1, 8'h00);
    settle();
    chk("R1 R3 stage 15 reached", {27'd0, seq_fired[0], seq_stage[3:0]}, 32'h0F);
    send(1, 8'h00); settle();
    chk("R3 pass zero fires", {27'd0, seq_fired[0], seq_stage[3:0]}, 32'h1F);
    chk("R5 mode0 others idle", {20'd0, seq_stage[15:4]}, 32'd0);
    chk("R7 trig", {31'd0, trig_out}, 32'd1);
    part_mode = 3'd5;
    do_arm();
    for (int n = 0; n < 4; n++) send(1, 8'h00);
    settle();
    chk("R1 reserved code as 0", {27'd0, seq_fired[0], seq_stage[3:0]}, 32'h04);
    do_arm();
  endtask

  task automatic t_sop();
    cfg_default();
    part_mode = 3'd0;
    sop_term[0*8 +: 8] = 8'h03;
    sop_term[1*8 +: 8] = 8'h0C;
    sop_en = 1'b1;
    do_arm();
    send(1, 8'h01); send(1, 8'h04); settle();
    chk("R6 partial products", {31'd0, trig_out}, 32'd0);
    send(0, 8'h0C); settle();
    chk("R6 invalid no hit", {31'd0, trig_out}, 32'd0);
    send(1, 8'h0C); settle();
    chk("R6 product hit", {30'd0, trig_out, trig_pulse}, 32'd3);
    send(1, 8'h03); settle();
    chk("R8 no second pulse", {30'd0, trig_out, trig_pulse}, 32'd2);
    sop_en = 1'b0;
    do_arm();
    send(1, 8'h03); settle();
    chk("R6 disabled", {31'd0, trig_out}, 32'd0);
    sop_en = 1'b1;
    sop_term = '0;
    send(1, 8'hFF); settle();
    chk("R6 zero term never", {31'd0, trig_out}, 32'd0);
    do_arm();
  endtask

  initial begin
    cfg_default();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_four4();
    t_twelve4();
    t_one16();
    t_sop();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule